// File: doc/BRIEF.md
# Serial Access Watchdog for a Real-Time Clock

This block sits between the host serial port of a real-time clock and its calendar counters. While the host holds the chip-enable line high, the block stops the timekeeping counters so that a multi-byte read or write sees a consistent time. The 1 Hz ticks that arrive during that window are not lost. They are held in a small saturating bank and released as seconds-increment pulses, one per clock, once the access closes.

A watchdog guards against a host that stops part way through an access. It is armed when the serial decoder reports a valid subaddress, not when chip-enable rises. It then counts 1 Hz ticks. On the second tick after arming (parameter `TRIP_TICKS`) with chip-enable still high, the access is treated as failed. The block pulses an interface-clear and a trip status, lets the counters run again, and locks the interface until chip-enable is seen low. Arming falls at an unknown point within a second, so the trip lands between one and two seconds after the subaddress. The tick that causes the trip is dropped, so each trip costs exactly one second.

Top module: `rtc_access_wdog`

## Requirements
- R1: `freeze_o` goes high in the cycle after `ce_lvl` is sampled high while the interface is not locked. It goes low in the cycle after `ce_lvl` is sampled low.
- R2: While frozen with `ce_lvl` still high, `sec_inc_o` stays low and every 1 Hz tick is added to a held count. The held count saturates at 2^`PEND_W`-1 (3 by default).
- R3: A `subaddr_ok` strobe sampled while the access is open arms the watchdog, including in the cycle `ce_lvl` first rises. Further strobes while armed do not restart the count. Strobes while locked or while `ce_lvl` is low have no effect.
- R4: The watchdog trips on the `TRIP_TICKS`-th tick (default 2) after arming, provided `ce_lvl` is still high. In the following cycle `if_clear_o` and `trip_o` are high for exactly one clock, and `freeze_o` is low.
- R5: `locked_o` is high from the trip cycle until the cycle after `ce_lvl` is sampled low. While locked, `freeze_o` stays low and strobes cannot open or arm an access.
- R6: A trip discards exactly the tripping tick. Ticks held before it are released after the trip, one `sec_inc_o` pulse per clock.
- R7: When an access ends normally, the held ticks are released one per clock, starting the cycle after `ce_lvl` is sampled low. A tick sampled in that same cycle is also counted. No time is lost.
- R8: If `ce_lvl` is sampled low in the same cycle as the tick that would trip, the access ends normally: no trip, no lockout, no lost tick.
- R9: Synchronous reset clears all state: not frozen, not armed, not locked, no held ticks, all outputs low. A reset during an access discards its held ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_lvl | input | 1 | Serial chip-enable level, high while an access is open |
| subaddr_ok | input | 1 | One-cycle strobe: valid subaddress received |
| tick_1hz | input | 1 | One-cycle 1 Hz prescaler tick |
| freeze_o | output | 1 | Stops the calendar counters while high |
| sec_inc_o | output | 1 | One-cycle seconds-increment enable to the counters |
| if_clear_o | output | 1 | One-cycle pulse forcing the serial interface idle |
| locked_o | output | 1 | Interface locked out after a trip, until chip-enable drops |
| trip_o | output | 1 | One-cycle watchdog trip status pulse |

## Verification
Two functions meet in one cycle here: ending an access and handling a 1 Hz tick. This happens in two forms. In the first, the tick that would be the second after arming arrives in the same cycle that chip-enable falls. The bench expects a normal close: no clear pulse, no lockout, and two increments in two consecutive cycles. In the second, a tick arrives in the cycle that closes an access that already holds several ticks. The bench expects the held bank to drain one pulse per cycle with the coincident tick added, and counts the pulses cycle by cycle against the total number of ticks fed in.

// File: rtl/awd_pkg.sv
package awd_pkg;

    typedef enum logic [1:0] {
        SES_IDLE  = 2'd0,
        SES_OPEN  = 2'd1,
        SES_ARMED = 2'd2,
        SES_LOCK  = 2'd3
    } ses_e;

    typedef struct packed {
        logic hold;     // access open and continuing: ticks are banked
        logic trip_go;  // tripping tick accepted this cycle
    } ses_ctl_t;

    localparam int DEF_TRIP_TICKS = 2;
    localparam int DEF_PEND_W     = 2;

    function automatic logic ses_frozen(input ses_e s);
        return (s == SES_OPEN) || (s == SES_ARMED);
    endfunction

endpackage

// File: rtl/awd_arm_timer.sv
module awd_arm_timer
    import awd_pkg::*;
#(
    parameter int TRIP_TICKS = DEF_TRIP_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic tick,
    output logic at_limit
);
    localparam int CNT_W = (TRIP_TICKS < 2) ? 1 : $clog2(TRIP_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIP_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = armed && tick && (cnt_q == LAST);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    assert_disarm_clears_R3: assert property (@(posedge clk) disable iff (rst)
        !armed |=> (cnt_q == '0));

endmodule

// File: rtl/awd_sess_fsm.sv
module awd_sess_fsm
    import awd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ce_lvl,
    input  logic     subaddr_ok,
    input  logic     at_limit,
    output ses_ctl_t ctl,
    output logic     armed,
    output logic     frozen,
    output logic     locked,
    output logic     trip_q
);
    ses_e st_q, st_d;

    always_comb begin
        ctl.hold    = ses_frozen(st_q) && ce_lvl;
        ctl.trip_go = (st_q == SES_ARMED) && ce_lvl && at_limit;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SES_IDLE:  if (ce_lvl) st_d = subaddr_ok ? SES_ARMED : SES_OPEN;
            SES_OPEN:  if (!ce_lvl) st_d = SES_IDLE;
                       else if (subaddr_ok) st_d = SES_ARMED;
            SES_ARMED: if (!ce_lvl) st_d = SES_IDLE;
                       else if (ctl.trip_go) st_d = SES_LOCK;
            SES_LOCK:  if (!ce_lvl) st_d = SES_IDLE;
            default:   st_d = SES_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SES_IDLE;
            trip_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            trip_q <= ctl.trip_go;
        end
    end

    assign armed  = (st_q == SES_ARMED);
    assign frozen = ses_frozen(st_q);
    assign locked = (st_q == SES_LOCK);

    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (locked && ce_lvl) |=> locked);

    assert_lock_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (locked && !ce_lvl) |=> !locked);

    assert_trip_locks_R4: assert property (@(posedge clk) disable iff (rst)
        trip_q |-> (locked && !frozen));

    assert_trip_single_R4: assert property (@(posedge clk) disable iff (rst)
        trip_q |=> !trip_q);

endmodule

// File: rtl/awd_tick_bank.sv
module awd_tick_bank
    import awd_pkg::*;
#(
    parameter int PEND_W = DEF_PEND_W
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic drop,
    input  logic tick,
    output logic sec_inc
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] pend_q;
    logic              pend_nz;

    assign pend_nz = (pend_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            sec_inc <= 1'b0;
        end else if (hold) begin
            sec_inc <= 1'b0;
            if (tick && !drop && (pend_q != PEND_MAX)) begin
                pend_q <= pend_q + 1'b1;
            end
        end else begin
            sec_inc <= tick || pend_nz;
            if (!tick && pend_nz) begin
                pend_q <= pend_q - 1'b1;
            end
        end
    end

    assert_no_inc_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        hold |=> !sec_inc);

    assert_drain_R7: assert property (@(posedge clk) disable iff (rst)
        (!hold && pend_nz) |=> sec_inc);

    assert_tick_passes_R6: assert property (@(posedge clk) disable iff (rst)
        (!hold && tick) |=> sec_inc);

endmodule

// File: rtl/rtc_access_wdog.sv
module rtc_access_wdog
    import awd_pkg::*;
#(
    parameter int TRIP_TICKS = DEF_TRIP_TICKS,
    parameter int PEND_W     = DEF_PEND_W
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_lvl,
    input  logic subaddr_ok,
    input  logic tick_1hz,
    output logic freeze_o,
    output logic sec_inc_o,
    output logic if_clear_o,
    output logic locked_o,
    output logic trip_o
);
    ses_ctl_t ctl;
    logic     armed;
    logic     at_limit;
    logic     trip_q;

    awd_arm_timer #(.TRIP_TICKS(TRIP_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .armed    (armed),
        .tick     (tick_1hz),
        .at_limit (at_limit)
    );

    awd_sess_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ce_lvl     (ce_lvl),
        .subaddr_ok (subaddr_ok),
        .at_limit   (at_limit),
        .ctl        (ctl),
        .armed      (armed),
        .frozen     (freeze_o),
        .locked     (locked_o),
        .trip_q     (trip_q)
    );

    awd_tick_bank #(.PEND_W(PEND_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .hold    (ctl.hold),
        .drop    (ctl.trip_go),
        .tick    (tick_1hz),
        .sec_inc (sec_inc_o)
    );

    assign if_clear_o = trip_q;
    assign trip_o     = trip_q;

    assert_ce_low_unfreezes_R1: assert property (@(posedge clk) disable iff (rst)
        !ce_lvl |=> !freeze_o);

    assert_locked_no_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (locked_o && subaddr_ok) |=> !freeze_o);

endmodule

// File: tb/sim_rtc_access_wdog.sv
module sim_rtc_access_wdog;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 29;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_lvl = 1'b0, subaddr_ok = 1'b0, tick_1hz = 1'b0;
    logic freeze_o, sec_inc_o, if_clear_o, locked_o, trip_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_access_wdog u0 (
        .clk(clk), .rst(rst), .ce_lvl(ce_lvl), .subaddr_ok(subaddr_ok),
        .tick_1hz(tick_1hz), .freeze_o(freeze_o), .sec_inc_o(sec_inc_o),
        .if_clear_o(if_clear_o), .locked_o(locked_o), .trip_o(trip_o)
    );

    // {ce, sa, tick, exp_freeze, exp_inc, exp_clear_and_trip, exp_locked}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b000_0000, // 0 idle
        7'b001_0100, // 1 free tick passes straight through (R7)
        7'b100_1000, // 2 access opens (R1)
        7'b110_1000, // 3 arm (R3)
        7'b101_1000, // 4 tick held (R2)
        7'b110_1000, // 5 second strobe, no restart (R3)
        7'b000_0100, // 6 normal end releases held tick (R7)
        7'b000_0000, // 7
        7'b110_1000, // 8 open and arm in one cycle (R3)
        7'b101_1000, // 9 first tick held
        7'b100_1000, // 10
        7'b101_0011, // 11 second tick trips (R4)
        7'b110_0101, // 12 locked, held tick released (R5, R6)
        7'b110_0001, // 13 strobe ignored while locked (R5)
        7'b000_0000, // 14 ce low ends lockout (R5)
        7'b101_1100, // 15 tick while idle, access opens
        7'b101_1000, // 16 held 1
        7'b111_1000, // 17 held 2, armed
        7'b101_1000, // 18 held 3
        7'b001_0100, // 19 end with coincident tick (R7)
        7'b000_0100, // 20
        7'b000_0100, // 21
        7'b000_0100, // 22 three held plus one coincident = four pulses
        7'b000_0000, // 23
        7'b110_1000, // 24 arm
        7'b101_1000, // 25 held 1
        7'b001_0100, // 26 ce low with would-be tripping tick (R8)
        7'b000_0100, // 27 no time lost (R8)
        7'b000_0000  // 28
    };

    task automatic chk(input string req, input logic act, input logic exp, input int at);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s step %0d: actual %b expected %b", req, at, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic t);
        ce_lvl = c; subaddr_ok = s; tick_1hz = t;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 freeze", freeze_o, 1'b0, -1);
        chk("R9 inc", sec_inc_o, 1'b0, -1);
        chk("R9 clear", if_clear_o, 1'b0, -1);
        chk("R9 locked", locked_o, 1'b0, -1);
        chk("R9 trip", trip_o, 1'b0, -1);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][6], VEC[i][5], VEC[i][4]);
            chk("R1/R5 freeze", freeze_o, VEC[i][3], i);
            chk("R2/R6/R7/R8 sec_inc", sec_inc_o, VEC[i][2], i);
            chk("R4/R8 if_clear", if_clear_o, VEC[i][1], i);
            chk("R4 trip", trip_o, VEC[i][1], i);
            chk("R5 locked", locked_o, VEC[i][0], i);
        end

        // R9: reset during an armed access discards held ticks
        step(1, 1, 0);
        step(1, 0, 1);
        rst = 1'b1;
        step(1, 0, 0);
        chk("R9 freeze in reset", freeze_o, 1'b0, 100);
        rst = 1'b0;
        step(0, 0, 0);
        chk("R9 held discarded", sec_inc_o, 1'b0, 101);
        step(0, 0, 0);
        chk("R9 held discarded", sec_inc_o, 1'b0, 102);

        // R9: reset clears lockout
        step(1, 1, 0);
        step(1, 0, 1);
        step(1, 0, 1);
        chk("R4 trip again", trip_o, 1'b1, 103);
        rst = 1'b1;
        step(1, 0, 0);
        chk("R9 lock cleared", locked_o, 1'b0, 104);
        rst = 1'b0;
        step(1, 1, 0);
        chk("R9 new access after reset", freeze_o, 1'b1, 105);
        step(0, 0, 0);
        chk("R1 freeze drops", freeze_o, 1'b0, 106);

        // R3: strobe with ce low has no effect
        step(0, 1, 0);
        step(0, 0, 0);
        chk("R3 strobe idle freeze", freeze_o, 1'b0, 107);
        step(1, 0, 0);
        step(1, 0, 1);
        step(1, 0, 1);
        chk("R3 not armed, no trip", trip_o, 1'b0, 108);
        chk("R3 not armed, no lock", locked_o, 1'b0, 109);
        step(0, 0, 0);
        chk("R7 release 1", sec_inc_o, 1'b1, 110);
        step(0, 0, 0);
        chk("R7 release 2", sec_inc_o, 1'b1, 111);
        step(0, 0, 0);
        chk("R7 bank empty", sec_inc_o, 1'b0, 112);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule